// File: doc/BRIEF.md
# Zero-Suppressed Hit Packet Assembler

This block turns one finished cluster record into a compact packet that carries only the pixels that fired. A record has four parts: a timestamp, the address of the 4x4 pixel group, a 16-bit hit map, and a time-over-threshold value for each of the sixteen pixels. The block writes a header that holds the timestamp, the group address and an encoded hit count. After the header it adds one 8-bit entry for each set bit of the hit map. Each entry is a pixel index followed by that pixel's time-over-threshold value.

The packet is 28 + 8n bits long for n hits. It leaves the block as a stream of 16-bit words under a valid/ready handshake, with a flag on the final word. The block takes a new record only after the current packet has gone out in full, so two packets never share the stream. Once the final word has been accepted, a one-cycle done pulse tells the capture side that its record has been consumed.

Top module: `hit_packet_asm`

## Requirements
- R1: The first 28 packet bits, counted from the MSB of the first word, hold three fields in this order: timestamp (bits 0..11), group address (bits 12..23), then the hit count minus one (bits 24..27).
- R2: After the header, each hit adds one 8-bit entry, made of the 4-bit pixel index followed by that pixel's value. The value comes from in_tot[4i+3:4i] for pixel i. Entries appear in ascending index order.
- R3: A packet with n hits is 28+8n bits long and goes out as ceil((28+8n)/16) words, MSB first. Bits past the end of the packet are zero. out_last is high on the final word and on no other word.
- R4: A record whose hit map is zero is accepted. It produces no output word, and done pulses in the following cycle.
- R5: While out_valid is high and out_ready is low, out_data and out_last hold their values and out_valid stays high.
- R6: in_ready is low from the cycle after a record with hits is accepted until its final word has been accepted. A record offered during that time is not taken and does not alter the stream.
- R7: done is high for exactly one cycle, the cycle after the final word is accepted.
- R8: After reset, out_valid and done are low and in_ready is high.
- R9: A full map gives a count field of 15 and a ten-word packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Cluster record offered |
| in_ready | output | 1 | Record can be taken this cycle |
| in_tstamp | input | 12 | Timestamp of the cluster |
| in_sp_addr | input | 12 | Address of the pixel group |
| in_hitmap | input | 16 | One bit per pixel that fired |
| in_tot | input | 64 | Per-pixel time-over-threshold, 4 bits each, pixel i at [4i+3:4i] |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 16 | Packet word, MSB first |
| out_last | output | 1 | Final word of the packet |
| done | output | 1 | One-cycle pulse after the packet is finished |

## Verification
If the shift register or the remaining-word counter goes wrong, the fault shows on the next word handshake. The word can then hold a misplaced header or entry field, out_last can come one word early or late, or the packet can run past its computed length. If the busy state goes wrong, in_ready rises while a packet is still open, or done fails to pulse in the cycle after the last handshake. Stall tests hold out_ready low across word boundaries, so any word lost or repeated under backpressure appears as a mismatch in the next word compared.

// File: rtl/hit_packet_asm.sv
module hit_packet_asm #(
  parameter int PIX    = 16,
  parameter int TOT_W  = 4,
  parameter int TS_W   = 12,
  parameter int ADDR_W = 12,
  parameter int OUT_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [TS_W-1:0]        in_tstamp,
  input  logic [ADDR_W-1:0]      in_sp_addr,
  input  logic [PIX-1:0]         in_hitmap,
  input  logic [PIX*TOT_W-1:0]   in_tot,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [OUT_W-1:0]       out_data,
  output logic                   out_last,
  output logic                   done
);
  localparam int IDX_W    = $clog2(PIX);
  localparam int HIT_W    = IDX_W + TOT_W;
  localparam int HDR_W    = TS_W + ADDR_W + IDX_W;
  localparam int MAX_BITS = HDR_W + PIX * HIT_W;
  localparam int WORDS    = (MAX_BITS + OUT_W - 1) / OUT_W;
  localparam int BUF_W    = WORDS * OUT_W;
  localparam int WC_W     = $clog2(WORDS + 1);

  logic             busy;
  logic [BUF_W-1:0] pkt_q, pkt_d;
  logic [WC_W-1:0]  left_q, left_d;
  int               pos;

  always_comb begin
    pkt_d = '0;
    pos   = 0;
    for (int i = 0; i < PIX; i++) begin
      if (in_hitmap[i]) begin
        pkt_d[BUF_W-1-HDR_W-pos*HIT_W -: HIT_W] = {IDX_W'(i), in_tot[i*TOT_W +: TOT_W]};
        pos = pos + 1;
      end
    end
    pkt_d[BUF_W-1 -: HDR_W] = {in_tstamp, in_sp_addr, IDX_W'(pos - 1)};
    left_d = WC_W'((HDR_W + pos * HIT_W + OUT_W - 1) / OUT_W);
  end

  wire take = in_valid && in_ready;
  wire emit = out_valid && out_ready;

  assign in_ready  = !busy;
  assign out_valid = busy;
  assign out_data  = pkt_q[BUF_W-1 -: OUT_W];
  assign out_last  = busy && (left_q == WC_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      pkt_q  <= '0;
      left_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (take) begin
        if (in_hitmap == '0) begin
          done <= 1'b1;
        end else begin
          busy   <= 1'b1;
          pkt_q  <= pkt_d;
          left_q <= left_d;
        end
      end else if (emit) begin
        if (out_last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          pkt_q  <= pkt_q << OUT_W;
          left_q <= left_q - WC_W'(1);
        end
      end
    end
  end
endmodule

module hit_packet_asm_chk #(
  parameter int PIX   = 16,
  parameter int TS_W  = 12,
  parameter int HDR_W = 28,
  parameter int HIT_W = 8,
  parameter int OUT_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [TS_W-1:0] in_tstamp,
  input logic [PIX-1:0]  in_hitmap,
  input logic            out_valid,
  input logic            out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic            out_last,
  input logic            done
);
  logic [7:0]      cnt, exp_words;
  logic [TS_W-1:0] ts_q;
  wire take = in_valid && in_ready;
  wire emit = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; exp_words <= '0; ts_q <= '0;
    end else if (take && in_hitmap != '0) begin
      cnt       <= '0;
      ts_q      <= in_tstamp;
      exp_words <= 8'((HDR_W + $countones(in_hitmap) * HIT_W + OUT_W - 1) / OUT_W);
    end else if (emit) begin
      cnt <= out_last ? 8'd0 : cnt + 8'd1;
    end
  end

  assert_hold_on_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  assert_no_accept_while_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past((out_valid && out_ready && out_last) || (in_valid && in_ready && in_hitmap == '0)));
  assert_word_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |-> (cnt + 8'd1 == exp_words));
  assert_last_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  assert_header_stamp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cnt == 8'd0 |-> out_data[OUT_W-1 -: TS_W] == ts_q);
endmodule

bind hit_packet_asm hit_packet_asm_chk #(
  .PIX(PIX), .TS_W(TS_W), .HDR_W(HDR_W), .HIT_W(HIT_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_tstamp(in_tstamp), .in_hitmap(in_hitmap), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last), .done(done)
);

// File: tb/hit_packet_asm_bench.sv
module hit_packet_asm_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_tstamp = '0;
  logic [11:0] in_sp_addr = '0;
  logic [15:0] in_hitmap = '0;
  logic [63:0] in_tot = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic        out_last;
  logic        done;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  hit_packet_asm u_hit_packet_asm (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [11:0] ts, input logic [11:0] ad,
                                input logic [15:0] map, input logic [63:0] tot,
                                output logic [159:0] v, output int nw);
    logic [159:0] acc;
    int n = 0;
    for (int i = 0; i < 16; i++) if (map[i]) n++;
    acc = {136'd0, ts, ad, 4'(n - 1)};
    for (int i = 0; i < 16; i++)
      if (map[i]) acc = (acc << 8) | {152'd0, 4'(i), tot[i*4 +: 4]};
    v  = acc << (160 - (28 + 8 * n));
    nw = (28 + 8 * n + 15) / 16;
  endfunction

  // stall: 0 none, 1 periodic, 2 long initial hold
  task automatic run_packet(input string req, input logic [11:0] ts, input logic [11:0] ad,
                            input logic [15:0] map, input logic [63:0] tot, input int stall);
    logic [159:0] v;
    int nw, k, cyc;
    bit held;
    logic [15:0] hw;
    logic hl;
    bit ready_low_ok;
    model(ts, ad, map, tot, v, nw);
    @(negedge clk);
    in_valid = 1'b1; in_tstamp = ts; in_sp_addr = ad; in_hitmap = map; in_tot = tot;
    @(negedge clk);
    in_tstamp = ~ts; in_sp_addr = ~ad; in_hitmap = 16'hFFFF; in_tot = ~tot;
    k = 0; cyc = 0; held = 0; ready_low_ok = 1;
    while (k < nw && cyc < 300) begin
      out_ready = (stall == 1) ? (cyc % 3 != 2) : (stall == 2) ? (cyc >= 5) : 1'b1;
      #1;
      if (held) begin
        chk(out_valid && out_data == hw && out_last == hl, "R5", "word held under stall",
            {15'd0, out_last, out_data}, {15'd0, hl, hw});
        held = 0;
      end
      if (in_ready) ready_low_ok = 0;
      if (out_valid && out_ready) begin
        chk(out_data == v[159-16*k -: 16], req, $sformatf("word %0d", k),
            {16'd0, out_data}, {16'd0, v[159-16*k -: 16]});
        chk(out_last == (k == nw - 1), "R3", $sformatf("last flag word %0d", k),
            {31'd0, out_last}, {31'd0, k == nw - 1});
        k++;
      end else if (out_valid) begin
        held = 1; hw = out_data; hl = out_last;
      end
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0; out_ready = 1'b0;
    chk(k == nw, "R3", "word count", k, nw);
    chk(ready_low_ok, "R6", "in_ready low while packet open", {31'd0, ready_low_ok}, 1);
    chk(done == 1'b1 && out_valid == 1'b0, "R7", "done after last word",
        {30'd0, done, out_valid}, 32'd2);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done width one cycle", {31'd0, done}, 0);
  endtask

  task automatic run_empty();
    @(negedge clk);
    in_valid = 1'b1; in_hitmap = '0; in_tstamp = 12'h5A5; in_sp_addr = 12'h0F0;
    #1 chk(in_ready, "R4", "empty record accepted", {31'd0, in_ready}, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(done == 1'b1 && out_valid == 1'b0, "R4", "empty map: done, no word",
        {30'd0, done, out_valid}, 32'd2);
    @(negedge clk);
    chk(done == 1'b0 && out_valid == 1'b0, "R4", "empty map quiet after",
        {30'd0, done, out_valid}, 0);
  endtask

  task automatic run_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !done && in_ready, "R8", "reset state",
        {29'd0, out_valid, done, in_ready}, 32'd1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] tot_a;
    tot_a = 64'hFEDC_BA98_7654_3210;
    run_reset();
    run_packet("R1", 12'hABC, 12'h123, 16'h0020, tot_a, 0);
    run_packet("R2", 12'h001, 12'hFFF, 16'h8001, 64'h3000_0000_0000_000C, 0);
    run_packet("R9", 12'h7E7, 12'h456, 16'hFFFF, tot_a, 1);
    run_packet("R2", 12'h3C3, 12'h0A0, 16'h0418, 64'h0123_4567_89AB_CDEF, 1);
    run_empty();
    run_packet("R5", 12'hF00, 12'h00F, 16'h8421, 64'h9999_5555_AAAA_3333, 2);
    run_packet("R3", 12'h111, 12'h222, 16'h00FF, tot_a, 1);
    run_packet("R1", 12'h000, 12'h000, 16'h4000, 64'h0F00_0000_0000_0000, 0);
    finish_run();
  end
endmodule